// File: doc/BRIEF.md
# Second-Order One-Bit Density Modulator

This block turns a stream of signed multi-bit samples into a single-bit stream whose long-run fraction of ones tracks the sample value. Two saturating integrators sit in cascade. A sign decision on the second one gives the output bit, and that bit chooses a feedback level of plus or minus FB. The level is subtracted at the input of both integrators. FB is set to 1.25 times the input full scale. A full-scale input therefore gives 90% or 10% ones, and the stream never sits at a constant level. A downstream decimation filter, not part of this block, recovers the value.

The decision bit is held in a two-state machine with the states `Q_LOW` and `Q_HIGH`. It has three transitions: RISE (`Q_LOW` to `Q_HIGH`, taken when the updated second integrator is zero or above), FALL (`Q_HIGH` to `Q_LOW`, taken when it is negative) and HOLD (anything else, including every cycle with the strobe low). The registered state is both the output and the feedback select. The output is launched on the rising clock edge, so a consumer samples it on the falling edge. The loop state moves only on cycles where `ce` is high.

Top module: `dsm2_modulator`

## Requirements
- R1: A synchronous reset clears both integrators to zero and puts the decision state in `Q_LOW`, so `density_out` reads 0 after reset. The first enabled cycle after reset then produces a 1 for any input value.
- R2: While `ce` is low, `density_out` and both integrators keep their values whatever `sample_in` does. Once `ce` returns high, the stream continues exactly as if the idle cycles had not happened.
- R3: With `sample_in` at zero, the count of ones over a 2000-cycle window is 1000 ± 6.
- R4: With `sample_in` = 32767 (positive full scale), the count of ones over 2000 cycles is 1800 ± 6, which is 90%.
- R5: With `sample_in` = -32768 (negative full scale), the count of ones over 2000 cycles is 200 ± 6, which is 10%.
- R6: The feedback level is +FB when the decision bit is 1 and -FB when it is 0, with FB = 5·2^(IN_W-3) (40960 by default). It is subtracted from the input of each integrator. A 1 therefore never lets the first integrator rise, and a 0 never lets it fall.
- R7: On each enabled cycle the first integrator adds `sample_in` - level. The second integrator adds the first integrator's newly updated value - level. `density_out` becomes 1 exactly when the updated second integrator is ≥ 0.
- R8: Both integrators clamp at +2^(ACC_W-1)-1 and -2^(ACC_W-1) instead of wrapping.
- R9: After every enabled cycle, `density_out` equals 1 exactly when the registered second integrator is non-negative.
- R10: With `sample_in` = 16384 (half scale), the count of ones over 2000 cycles is 1400 ± 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Modulator clock; state and output change on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Clock-enable strobe; the loop advances only when high |
| sample_in | input | IN_W | Signed two's-complement input sample |
| density_out | output | 1 | One-bit density stream |

## Verification
The situation hardest to reach is integrator clamping. At the default width, a stable second-order loop keeps its integrators far below the 24-bit rails for any legal input. The bench therefore adds a second instance with the accumulator narrowed to 18 bits. It drives sustained full-scale inputs and abrupt swings from one full-scale value to the other, which push both integrators into their clamps. A behavioural model with the same limits follows this instance on every cycle. Randomly gated strobes are mixed into these runs, so clamped state must survive idle stretches intact.

// File: rtl/dsm2_pkg.sv
package dsm2_pkg;

    // Number of cascaded integrators in the loop.
    localparam int NSTAGE = 2;

    // Decision state of the one-bit quantizer; the encoding is the output bit.
    typedef enum logic {
        Q_LOW  = 1'b0,
        Q_HIGH = 1'b1
    } qstate_e;

endpackage

// File: rtl/dsm2_integrator.sv
module dsm2_integrator #(
    parameter int ACC_W = 24
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic signed [ACC_W-1:0] din,
    input  logic signed [ACC_W-1:0] fb,
    output logic signed [ACC_W-1:0] acc_q,
    output logic signed [ACC_W-1:0] acc_d
);

    // Two guard bits hold the sum of three ACC_W-bit terms exactly.
    localparam int SUM_W = ACC_W + 2;
    localparam logic signed [SUM_W-1:0] SAT_HI = {{3{1'b0}}, {(ACC_W-1){1'b1}}};
    localparam logic signed [SUM_W-1:0] SAT_LO = {{3{1'b1}}, {(ACC_W-1){1'b0}}};

    logic signed [SUM_W-1:0] sum;

    always_comb begin
        sum = SUM_W'(acc_q) + SUM_W'(din) - SUM_W'(fb);
        if (sum > SAT_HI) begin
            acc_d = SAT_HI[ACC_W-1:0];
        end else if (sum < SAT_LO) begin
            acc_d = SAT_LO[ACC_W-1:0];
        end else begin
            acc_d = sum[ACC_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (en) begin
            acc_q <= acc_d;
        end
    end

endmodule

// File: rtl/dsm2_quantizer.sv
module dsm2_quantizer
    import dsm2_pkg::*;
#(
    parameter int ACC_W  = 24,
    parameter int FB_MAG = 40960
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic signed [ACC_W-1:0] decide,
    output logic                    bit_out,
    output logic signed [ACC_W-1:0] fb_level
);

    localparam logic signed [ACC_W-1:0] LVL_POS = ACC_W'(FB_MAG);
    localparam logic signed [ACC_W-1:0] LVL_NEG = -LVL_POS;

    qstate_e state_q;
    qstate_e state_d;
    logic    non_neg;

    assign non_neg = ~decide[ACC_W-1];

    // Next state: RISE, FALL or HOLD.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            Q_LOW:  if (non_neg)  state_d = Q_HIGH;
            Q_HIGH: if (!non_neg) state_d = Q_LOW;
        endcase
    end

    // State register; it moves only on strobed cycles.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= Q_LOW;
        end else if (en) begin
            state_q <= state_d;
        end
    end

    // Outputs: the stream bit and the feedback level it selects.
    always_comb begin
        unique case (state_q)
            Q_LOW: begin
                bit_out  = 1'b0;
                fb_level = LVL_NEG;
            end
            Q_HIGH: begin
                bit_out  = 1'b1;
                fb_level = LVL_POS;
            end
        endcase
    end

endmodule

// File: rtl/dsm2_modulator.sv
module dsm2_modulator
    import dsm2_pkg::*;
#(
    parameter int IN_W  = 16,
    parameter int ACC_W = 24
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   ce,
    input  logic signed [IN_W-1:0] sample_in,
    output logic                   density_out
);

    // Feedback magnitude: 1.25 times the input full scale 2^(IN_W-1).
    localparam int FB_MAG = 5 << (IN_W - 3);

    logic signed [ACC_W-1:0] fb_level;
    logic signed [ACC_W-1:0] stage_in [NSTAGE];
    logic signed [ACC_W-1:0] acc_q    [NSTAGE];
    logic signed [ACC_W-1:0] acc_d    [NSTAGE];

    generate
        for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
            if (g == 0) begin : g_head
                assign stage_in[g] = ACC_W'(sample_in);
            end else begin : g_tail
                // The updated value of the stage before feeds this one in the same cycle.
                assign stage_in[g] = acc_d[g-1];
            end

            dsm2_integrator #(
                .ACC_W (ACC_W)
            ) u_int (
                .clk   (clk),
                .rst   (rst),
                .en    (ce),
                .din   (stage_in[g]),
                .fb    (fb_level),
                .acc_q (acc_q[g]),
                .acc_d (acc_d[g])
            );
        end
    endgenerate

    dsm2_quantizer #(
        .ACC_W  (ACC_W),
        .FB_MAG (FB_MAG)
    ) u_quant (
        .clk      (clk),
        .rst      (rst),
        .en       (ce),
        .decide   (acc_d[NSTAGE-1]),
        .bit_out  (density_out),
        .fb_level (fb_level)
    );

endmodule

// File: rtl/dsm2_checker.sv
module dsm2_checker #(
    parameter int ACC_W = 24
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    en,
    input logic                    bit_out,
    input logic signed [ACC_W-1:0] s1,
    input logic signed [ACC_W-1:0] s2
);

    // R1: reset clears the stream bit and both integrators.
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (!bit_out && s1 == '0 && s2 == '0));

    // R2: no strobe, no movement.
    a_r2_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(bit_out) && $stable(s1) && $stable(s2)));

    // R9: the output bit agrees with the sign of the second integrator.
    a_r9_sign_match: assert property (@(posedge clk) disable iff (rst)
        en |=> (bit_out == !s2[ACC_W-1]));

    // R6: a 1 subtracts +FB, so the first integrator cannot rise.
    a_r6_fb_high: assert property (@(posedge clk) disable iff (rst)
        (en && bit_out) |=> ($signed(s1) <= $signed($past(s1))));

    // R6: a 0 subtracts -FB, so the first integrator cannot fall.
    a_r6_fb_low: assert property (@(posedge clk) disable iff (rst)
        (en && !bit_out) |=> ($signed(s1) >= $signed($past(s1))));

    // R8: a non-negative first integrator that is pushed upward never wraps negative.
    a_r8_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (en && !bit_out && !s1[ACC_W-1]) |=> !s1[ACC_W-1]);

endmodule

bind dsm2_modulator dsm2_checker #(
    .ACC_W (ACC_W)
) u_dsm2_checker (
    .clk     (clk),
    .rst     (rst),
    .en      (ce),
    .bit_out (density_out),
    .s1      (acc_q[0]),
    .s2      (acc_q[1])
);

// File: tb/dsm2_modulator_bench.sv
module dsm2_modulator_bench;

    localparam int    CLK_P   = 10;
    localparam int    IN_W    = 16;
    localparam int    WIDE_W  = 24;
    localparam int    NARROW_W = 18;
    localparam longint FB     = 40960;
    localparam int    WIN     = 2000;
    localparam int    TOL     = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ce  = 1'b0;
    logic signed [IN_W-1:0] xin = '0;
    logic dout_w;
    logic dout_n;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // Reference model state, one set per instance.
    longint w1 = 0, w2 = 0, n1 = 0, n2 = 0;
    bit     wb = 1'b0, nb = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    dsm2_modulator #(.IN_W(IN_W), .ACC_W(WIDE_W)) u_dsm2_modulator (
        .clk(clk), .rst(rst), .ce(ce), .sample_in(xin), .density_out(dout_w));

    dsm2_modulator #(.IN_W(IN_W), .ACC_W(NARROW_W)) u_narrow (
        .clk(clk), .rst(rst), .ce(ce), .sample_in(xin), .density_out(dout_n));

    function automatic longint clampv(input longint v, input int w);
        longint hi;
        longint lo;
        hi = (longint'(1) <<< (w - 1)) - 1;
        lo = -(longint'(1) <<< (w - 1));
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

    // R6/R7/R8: behavioural loop update.
    task automatic model_step(input longint x);
        longint lv;
        lv = wb ? FB : -FB;
        w1 = clampv(w1 + x - lv, WIDE_W);
        w2 = clampv(w2 + w1 - lv, WIDE_W);
        wb = (w2 >= 0);
        lv = nb ? FB : -FB;
        n1 = clampv(n1 + x - lv, NARROW_W);
        n2 = clampv(n2 + n1 - lv, NARROW_W);
        nb = (n2 >= 0);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One cycle: compare at the falling edge, then drive the next inputs.
    task automatic tick(input bit r, input bit e, input longint x, input string tag);
        @(negedge clk);
        check(dout_w === wb, {tag, " wide stream"}, int'(dout_w), int'(wb));
        check(dout_n === nb, {"R8 ", tag, " narrow stream"}, int'(dout_n), int'(nb));
        rst = r;
        ce  = e;
        xin = x[IN_W-1:0];
        if (r) begin
            w1 = 0; w2 = 0; wb = 1'b0;
            n1 = 0; n2 = 0; nb = 1'b0;
        end else if (e) begin
            model_step(x);
        end
    endtask

    task automatic run_level(input longint x, input string tag);
        int ones;
        int exp;
        repeat (200) tick(1'b0, 1'b1, x, tag);
        ones = 0;
        for (int i = 0; i < WIN; i++) begin
            tick(1'b0, 1'b1, x, tag);
            ones += int'(dout_w);
        end
        exp = int'((longint'(WIN) * (x + FB)) / (2 * FB));
        check((ones >= exp - TOL) && (ones <= exp + TOL), {tag, " ones count"}, ones, exp);
    endtask

    initial begin
        // R1: reset state, then the first enabled bit.
        repeat (3) tick(1'b1, 1'b0, 0, "R1");
        tick(1'b0, 1'b0, 0, "R1");
        check(dout_w == 1'b0, "R1 reset output", int'(dout_w), 0);
        tick(1'b0, 1'b1, -32768, "R1");
        tick(1'b0, 1'b0, 0, "R1");
        check(dout_w == 1'b1, "R1 first bit", int'(dout_w), 1);

        // R3, R4, R5, R10: density at fixed levels.
        run_level(0, "R3");
        run_level(32767, "R4");
        run_level(-32768, "R5");
        run_level(16384, "R10");

        // R8: full-scale swings drive the narrow instance into its clamps.
        for (int k = 0; k < 6; k++) begin
            repeat (150) tick(1'b0, 1'b1, 32767, "R8 swing");
            repeat (150) tick(1'b0, 1'b1, -32768, "R8 swing");
        end

        // R2: idle cycles with a changing input leave the output untouched.
        begin
            bit held;
            tick(1'b0, 1'b1, 1234, "R2");
            tick(1'b0, 1'b0, -5000, "R2");
            held = dout_w;
            for (int i = 0; i < 20; i++) begin
                tick(1'b0, 1'b0, longint'(i * 3001 - 30000), "R2");
                check(dout_w == held, "R2 idle hold", int'(dout_w), int'(held));
            end
        end

        // R2/R8: random strobes over random and extreme inputs.
        for (int i = 0; i < 1500; i++) begin
            longint x;
            x = (i % 300 < 100) ? 32767 : longint'($signed(16'($urandom)));
            tick(1'b0, 1'($urandom_range(0, 3) != 0), x, "R2 gated");
        end

        // R7: random inputs, every cycle strobed.
        for (int i = 0; i < 800; i++) begin
            tick(1'b0, 1'b1, longint'($signed(16'($urandom))), "R7 random");
        end

        // R1: reset in the middle of activity.
        tick(1'b1, 1'b1, 20000, "R1 midrun");
        tick(1'b0, 1'b0, 20000, "R1 midrun");
        check(dout_w == 1'b0, "R1 midrun reset output", int'(dout_w), 0);
        tick(1'b0, 1'b1, 32767, "R1 midrun");
        tick(1'b0, 1'b0, 0, "R1 midrun");
        check(dout_w == 1'b1, "R1 midrun first bit", int'(dout_w), 1);
        repeat (50) tick(1'b0, 1'b1, -1000, "R6 small");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule